// File: doc/BRIEF.md
# PCI Function Command and Status Registers

This block holds the 16-bit command word and the 16-bit status word of one PCI function's configuration header. The two words share one 32-bit configuration dword, selected by a dword index: the command word sits in the low half (byte offset 04h) and the status word in the high half (byte offset 06h). Software reaches them through a plain single-cycle read/write port with four byte-lane enables. The read data is combinational from the register state.

The bus interface logic reports events on one-cycle strobes: detected address or data parity errors, an observed PERR, whether this function currently owns the bus, master aborts and target aborts it received, target aborts it issued, and system errors it signalled. Each event sets a sticky status flag. Two of the flags are gated by enables held in the command word. Software clears a flag by writing a 1 to it. The capability fields of the status word are fixed.

Two resets are used. The global reset clears everything. The function reset returns the command word to zero but leaves the sticky status flags alone. The decode enables and the two error-reporting enables are driven out to the rest of the function.

Top module: `pci_cmdstat_regs`

## Requirements
- R1: While and after the global reset the dword reads 0210_0000h: the command word is 0000h, the status word is 0210h, and io_en, mem_en, perr_resp_en and serr_en are all 0.
- R2: Command bits 0 (io_en), 1 (mem_en), 6 (perr_resp_en) and 8 (serr_en) are read/write and appear on their output ports. All other command bits read 0.
- R3: Byte enable n gates write-data bits 8n+7 to 8n. A lane that is not enabled leaves its bits unchanged.
- R4: The status flags at dword bits 24, 27, 28, 29, 30 and 31 (status bits 8, 11 to 15) clear when a 1 is written to them. Writing a 0 to them has no effect.
- R5: Status bits 10:9 always read 01b and status bit 4 always reads 1. Status bits 0 to 3 and 5 to 7 always read 0. Writes do not change any of them.
- R6: Status bit 15 sets in the cycle after an address-parity or a data-parity error strobe.
- R7: Status bit 14 sets after a system-error strobe only when serr_en is 1.
- R8: Status bit 13 sets on a received master abort, bit 12 on a received target abort, and bit 11 on a target abort that this function issued.
- R9: Status bit 8 sets only when PERR is observed, this function is bus master and perr_resp_en is 1, all in the same cycle.
- R10: When a set event and a write-one-to-clear reach the same flag in the same cycle, the flag ends up set.
- R11: The function reset returns the command word to 0000h and keeps every status flag unchanged. The global reset clears the status flags as well.
- R12: Only the dword index CFG_DWORD (default 1) is decoded. At any other index, writes are ignored and the read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| grst_n | input | 1 | Global reset, synchronous, active low |
| frst_n | input | 1 | Function reset, synchronous, active low |
| cfg_addr | input | ADDR_W | Configuration dword index |
| cfg_wr | input | 1 | Write strobe |
| cfg_be | input | 4 | Byte-lane write enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data: status word in bits 31:16, command word in bits 15:0 |
| ev_addr_perr | input | 1 | Address parity error detected |
| ev_data_perr | input | 1 | Data parity error detected |
| ev_perr_seen | input | 1 | PERR asserted by any agent |
| ev_is_master | input | 1 | This function is currently bus master |
| ev_mabort | input | 1 | Master abort received |
| ev_tabort_rcv | input | 1 | Target abort received |
| ev_tabort_sig | input | 1 | Target abort issued by this function |
| ev_serr_sig | input | 1 | System error signalled |
| io_en | output | 1 | I/O-space response enable |
| mem_en | output | 1 | Memory-space response enable |
| perr_resp_en | output | 1 | Parity error response enable |
| serr_en | output | 1 | System error enable |

## Verification
A table of writes tries the command word with every lane pattern: all lanes, a single low lane, a single high lane, and all-ones data. Together these separate the writable command bits from the fixed ones and show that each lane is gated on its own. Directed tests then fire each event alone, the gated events with only part of their conditions, and an event in the same cycle as a clear of its flag. Those cases show which flag each event drives, confirm that both gating conditions are needed, and show that the set wins. Last, the two resets are applied in turn, so the flags that survive a function reset can be told apart from those cleared by the global reset.

// File: rtl/pci_cs_pkg.sv
package pci_cs_pkg;

   localparam int CMD_W = 16;
   localparam int STAT_W = 16;

   localparam int CMD_IO = 0;
   localparam int CMD_MEM = 1;
   localparam int CMD_PERR = 6;
   localparam int CMD_SERR = 8;
   localparam logic [CMD_W-1:0] CMD_RW_MASK =
      CMD_W'((1 << CMD_IO) | (1 << CMD_MEM) | (1 << CMD_PERR) | (1 << CMD_SERR));

   localparam logic [STAT_W-1:0] STAT_FIXED = 16'h0210;

   // sticky flag slots, in set-vector order
   localparam int N_STICKY = 6;
   localparam int SL_DPAR = 0;
   localparam int SL_TABT_SIG = 1;
   localparam int SL_TABT_RCV = 2;
   localparam int SL_MABT = 3;
   localparam int SL_SERR = 4;
   localparam int SL_PERR = 5;

   function automatic int sticky_pos(input int slot);
      case (slot)
         SL_DPAR: return 8;
         SL_TABT_SIG: return 11;
         SL_TABT_RCV: return 12;
         SL_MABT: return 13;
         SL_SERR: return 14;
         default: return 15;
      endcase
   endfunction

endpackage

// File: rtl/cs_lane_mask.sv
module cs_lane_mask #(
   parameter int DATA_W = 32,
   parameter int LANE_W = 8,
   localparam int N_LANE = DATA_W / LANE_W
) (
   input  logic [N_LANE-1:0] be_i,
   output logic [DATA_W-1:0] mask_o
);
   for (genvar l = 0; l < N_LANE; l++) begin : g_lane
      assign mask_o[l*LANE_W +: LANE_W] = {LANE_W{be_i[l]}};
   end
endmodule

// File: rtl/cs_sticky_bit.sv
module cs_sticky_bit #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   if (SET_WINS) begin : g_set_first
      always_ff @(posedge clk) begin
         if (!rst_n) q_o <= 1'b0;
         else        q_o <= set_i | (q_o & ~clr_i);
      end
   end else begin : g_clr_first
      always_ff @(posedge clk) begin
         if (!rst_n) q_o <= 1'b0;
         else        q_o <= (q_o | set_i) & ~clr_i;
      end
   end
endmodule

// File: rtl/cs_cmd_reg.sv
module cs_cmd_reg
   import pci_cs_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CMD_W-1:0] wmask,
   input  logic [CMD_W-1:0] wdata,
   output logic [CMD_W-1:0] cmd_q
);
   logic [CMD_W-1:0] upd;
   assign upd = wr_en ? (wmask & CMD_RW_MASK) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) cmd_q <= '0;
      else        cmd_q <= (cmd_q & ~upd) | (wdata & upd);
   end
endmodule

// File: rtl/cs_status_reg.sv
module cs_status_reg
   import pci_cs_pkg::*;
#(
   parameter bit SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              grst_n,
   input  logic              wr_en,
   input  logic [STAT_W-1:0] wmask,
   input  logic [STAT_W-1:0] wdata,
   input  logic              perr_resp_en,
   input  logic              serr_en,
   input  logic              ev_addr_perr,
   input  logic              ev_data_perr,
   input  logic              ev_perr_seen,
   input  logic              ev_is_master,
   input  logic              ev_mabort,
   input  logic              ev_tabort_rcv,
   input  logic              ev_tabort_sig,
   input  logic              ev_serr_sig,
   output logic [STAT_W-1:0] stat_q
);
   logic [N_STICKY-1:0] set_v;
   logic [N_STICKY-1:0] sticky_q;
   logic [STAT_W-1:0]   clr_v;

   always_comb begin
      set_v = '0;
      set_v[SL_DPAR]     = ev_perr_seen & ev_is_master & perr_resp_en;
      set_v[SL_TABT_SIG] = ev_tabort_sig;
      set_v[SL_TABT_RCV] = ev_tabort_rcv;
      set_v[SL_MABT]     = ev_mabort;
      set_v[SL_SERR]     = ev_serr_sig & serr_en;
      set_v[SL_PERR]     = ev_addr_perr | ev_data_perr;
   end

   assign clr_v = wr_en ? (wmask & wdata) : '0;

   for (genvar i = 0; i < N_STICKY; i++) begin : g_sticky
      localparam int POS = sticky_pos(i);
      cs_sticky_bit #(.SET_WINS(SET_WINS)) u_bit (
         .clk   (clk),
         .rst_n (grst_n),
         .set_i (set_v[i]),
         .clr_i (clr_v[POS]),
         .q_o   (sticky_q[i])
      );
   end

   always_comb begin
      stat_q = STAT_FIXED;
      for (int i = 0; i < N_STICKY; i++) stat_q[sticky_pos(i)] = sticky_q[i];
   end
endmodule

// File: rtl/pci_cmdstat_regs.sv
module pci_cmdstat_regs
   import pci_cs_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 6,
   parameter int CFG_DWORD = 1,
   parameter bit SET_WINS  = 1'b1,
   localparam int N_BE = DATA_W / 8
) (
   input  logic              clk,
   input  logic              grst_n,
   input  logic              frst_n,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic              cfg_wr,
   input  logic [N_BE-1:0]   cfg_be,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   input  logic              ev_addr_perr,
   input  logic              ev_data_perr,
   input  logic              ev_perr_seen,
   input  logic              ev_is_master,
   input  logic              ev_mabort,
   input  logic              ev_tabort_rcv,
   input  logic              ev_tabort_sig,
   input  logic              ev_serr_sig,
   output logic              io_en,
   output logic              mem_en,
   output logic              perr_resp_en,
   output logic              serr_en
);
   if (DATA_W != CMD_W + STAT_W) begin : g_bad_width
      $error("pci_cmdstat_regs: DATA_W must equal 32");
   end
   if (CFG_DWORD < 0 || CFG_DWORD >= (1 << ADDR_W)) begin : g_bad_index
      $error("pci_cmdstat_regs: CFG_DWORD does not fit ADDR_W");
   end

   logic              hit;
   logic              wr_en;
   logic              cmd_rst_n;
   logic [DATA_W-1:0] wmask;
   logic [CMD_W-1:0]  cmd_q;
   logic [STAT_W-1:0] stat_q;

   assign hit       = (cfg_addr == ADDR_W'(CFG_DWORD));
   assign wr_en     = cfg_wr & hit;
   assign cmd_rst_n = grst_n & frst_n;

   cs_lane_mask #(.DATA_W(DATA_W), .LANE_W(8)) u_mask (
      .be_i   (cfg_be),
      .mask_o (wmask)
   );

   cs_cmd_reg u_cmd (
      .clk   (clk),
      .rst_n (cmd_rst_n),
      .wr_en (wr_en),
      .wmask (wmask[CMD_W-1:0]),
      .wdata (cfg_wdata[CMD_W-1:0]),
      .cmd_q (cmd_q)
   );

   assign io_en        = cmd_q[CMD_IO];
   assign mem_en       = cmd_q[CMD_MEM];
   assign perr_resp_en = cmd_q[CMD_PERR];
   assign serr_en      = cmd_q[CMD_SERR];

   cs_status_reg #(.SET_WINS(SET_WINS)) u_stat (
      .clk           (clk),
      .grst_n        (grst_n),
      .wr_en         (wr_en),
      .wmask         (wmask[DATA_W-1:CMD_W]),
      .wdata         (cfg_wdata[DATA_W-1:CMD_W]),
      .perr_resp_en  (perr_resp_en),
      .serr_en       (serr_en),
      .ev_addr_perr  (ev_addr_perr),
      .ev_data_perr  (ev_data_perr),
      .ev_perr_seen  (ev_perr_seen),
      .ev_is_master  (ev_is_master),
      .ev_mabort     (ev_mabort),
      .ev_tabort_rcv (ev_tabort_rcv),
      .ev_tabort_sig (ev_tabort_sig),
      .ev_serr_sig   (ev_serr_sig),
      .stat_q        (stat_q)
   );

   assign cfg_rdata = hit ? {stat_q, cmd_q} : '0;
endmodule

// File: rtl/cs_cmdstat_chk.sv
module cs_cmdstat_chk #(
   parameter int ADDR_W    = 6,
   parameter int CFG_DWORD = 1
) (
   input logic              clk,
   input logic              grst_n,
   input logic              frst_n,
   input logic [ADDR_W-1:0] cfg_addr,
   input logic              cfg_wr,
   input logic [3:0]        cfg_be,
   input logic [31:0]       cfg_wdata,
   input logic [31:0]       cfg_rdata,
   input logic              ev_addr_perr,
   input logic              ev_data_perr,
   input logic              ev_perr_seen,
   input logic              ev_is_master,
   input logic              ev_serr_sig,
   input logic              io_en,
   input logic              mem_en,
   input logic              perr_resp_en,
   input logic              serr_en,
   input logic [15:0]       stat_q
);
   logic sel;
   assign sel = (cfg_addr == ADDR_W'(CFG_DWORD));

   p_fixed_fields_r5: assert property (@(posedge clk) disable iff (!grst_n)
      sel |-> (cfg_rdata[26:25] == 2'b01 && cfg_rdata[20] && cfg_rdata[23:21] == 3'b000
               && cfg_rdata[19:16] == 4'h0));

   p_w1c_only_r4: assert property (@(posedge clk) disable iff (!grst_n)
      $fell(stat_q[15]) |-> $past(cfg_wr && sel && cfg_be[3] && cfg_wdata[31]));

   p_perr_sets_r6: assert property (@(posedge clk) disable iff (!grst_n)
      ($past(grst_n) && $past(ev_addr_perr || ev_data_perr)) |-> stat_q[15]);

   p_serr_gate_r7: assert property (@(posedge clk) disable iff (!grst_n)
      $rose(stat_q[14]) |-> $past(serr_en && ev_serr_sig));

   p_dpar_gate_r9: assert property (@(posedge clk) disable iff (!grst_n)
      $rose(stat_q[8]) |-> $past(ev_perr_seen && ev_is_master && perr_resp_en));

   p_frst_cmd_r11: assert property (@(posedge clk) disable iff (!grst_n)
      ($past(grst_n) && !$past(frst_n)) |-> !(io_en || mem_en || perr_resp_en || serr_en));

   p_frst_keep_r11: assert property (@(posedge clk) disable iff (!grst_n)
      ($past(grst_n) && !$past(frst_n) && $past(stat_q[13])) |-> stat_q[13]);

   p_miss_zero_r12: assert property (@(posedge clk) disable iff (!grst_n)
      !sel |-> (cfg_rdata == 32'h0));
endmodule

bind pci_cmdstat_regs cs_cmdstat_chk #(.ADDR_W(ADDR_W), .CFG_DWORD(CFG_DWORD)) u_chk (
   .clk          (clk),
   .grst_n       (grst_n),
   .frst_n       (frst_n),
   .cfg_addr     (cfg_addr),
   .cfg_wr       (cfg_wr),
   .cfg_be       (cfg_be),
   .cfg_wdata    (cfg_wdata),
   .cfg_rdata    (cfg_rdata),
   .ev_addr_perr (ev_addr_perr),
   .ev_data_perr (ev_data_perr),
   .ev_perr_seen (ev_perr_seen),
   .ev_is_master (ev_is_master),
   .ev_serr_sig  (ev_serr_sig),
   .io_en        (io_en),
   .mem_en       (mem_en),
   .perr_resp_en (perr_resp_en),
   .serr_en      (serr_en),
   .stat_q       (stat_q)
);

// File: tb/pci_cmdstat_regs_tb.sv
module pci_cmdstat_regs_tb;
   localparam int CLK_P = 10;
   localparam int AW = 6;
   localparam int N_VEC = 7;
   // each entry: {byte enables, write data, expected dword 1 read}
   localparam logic [67:0] VEC [N_VEC] = '{
      {4'hF, 32'h0000_0143, 32'h0210_0143},
      {4'h1, 32'h0000_0000, 32'h0210_0100},
      {4'h2, 32'hFFFF_FFFF, 32'h0210_0100},
      {4'hF, 32'hFFFF_FEBC, 32'h0210_0000},
      {4'h1, 32'h0000_00FF, 32'h0210_0043},
      {4'hF, 32'hFFFF_FFFF, 32'h0210_0143},
      {4'h2, 32'h0000_0000, 32'h0210_0043}
   };

   logic clk = 1'b0;
   logic grst_n = 1'b0, frst_n = 1'b1;
   logic [AW-1:0] cfg_addr = AW'(1);
   logic cfg_wr = 1'b0;
   logic [3:0] cfg_be = '0;
   logic [31:0] cfg_wdata = '0, cfg_rdata;
   logic ev_addr_perr = 0, ev_data_perr = 0, ev_perr_seen = 0, ev_is_master = 0;
   logic ev_mabort = 0, ev_tabort_rcv = 0, ev_tabort_sig = 0, ev_serr_sig = 0;
   logic io_en, mem_en, perr_resp_en, serr_en;
   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #(CLK_P/2) clk = ~clk;

   pci_cmdstat_regs u_dut (
      .clk(clk), .grst_n(grst_n), .frst_n(frst_n), .cfg_addr(cfg_addr),
      .cfg_wr(cfg_wr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .ev_addr_perr(ev_addr_perr), .ev_data_perr(ev_data_perr),
      .ev_perr_seen(ev_perr_seen), .ev_is_master(ev_is_master),
      .ev_mabort(ev_mabort), .ev_tabort_rcv(ev_tabort_rcv),
      .ev_tabort_sig(ev_tabort_sig), .ev_serr_sig(ev_serr_sig),
      .io_en(io_en), .mem_en(mem_en), .perr_resp_en(perr_resp_en), .serr_en(serr_en)
   );

   task automatic check_rd(input logic [AW-1:0] a, input logic [31:0] exp, input string req);
      cfg_addr = a;
      #1;
      n_chk++;
      if (cfg_rdata !== exp) begin
         n_fail++;
         $display("FAIL %s: read %h expected %h", req, cfg_rdata, exp);
      end
   endtask

   task automatic check_out(input logic [3:0] exp, input string req);
      n_chk++;
      if ({serr_en, perr_resp_en, mem_en, io_en} !== exp) begin
         n_fail++;
         $display("FAIL %s: enables %b expected %b", req, {serr_en, perr_resp_en, mem_en, io_en}, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [3:0] be, input logic [31:0] d);
      cfg_addr = a; cfg_be = be; cfg_wdata = d; cfg_wr = 1'b1;
      @(posedge clk); @(negedge clk);
      cfg_wr = 1'b0; cfg_be = '0; cfg_addr = AW'(1);
   endtask

   task automatic cycle();
      @(posedge clk); @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_rd(AW'(1), 32'h0210_0000, "R1 in reset");
      grst_n = 1'b1;
      cycle();
      check_rd(AW'(1), 32'h0210_0000, "R1 after reset");
      check_out(4'b0000, "R1 enables");

      // R2 R3 R5: table of command writes
      for (int i = 0; i < N_VEC; i++) begin
         wr(AW'(1), VEC[i][67:64], VEC[i][63:32]);
         check_rd(AW'(1), VEC[i][31:0], $sformatf("R2/R3/R5 vector %0d", i));
      end
      check_out(4'b0111, "R2 enables after table");

      // R12: other dword index
      wr(AW'(2), 4'hF, 32'hFFFF_FFFF);
      check_rd(AW'(1), 32'h0210_0043, "R12 write elsewhere ignored");
      check_rd(AW'(2), 32'h0000_0000, "R12 read elsewhere zero");

      // R6 address parity
      ev_addr_perr = 1; cycle(); ev_addr_perr = 0;
      check_rd(AW'(1), 32'h8210_0043, "R6 address parity sets bit 15");
      // R4 write zero, R3 wrong lane, then clear
      wr(AW'(1), 4'h8, 32'h0000_0000);
      check_rd(AW'(1), 32'h8210_0043, "R4 write zero no effect");
      wr(AW'(1), 4'h4, 32'hFFFF_FFFF);
      check_rd(AW'(1), 32'h8210_0043, "R3 lane 2 cannot clear bit 15");
      wr(AW'(1), 4'h8, 32'h8000_0000);
      check_rd(AW'(1), 32'h0210_0043, "R4 write one clears bit 15");
      ev_data_perr = 1; cycle(); ev_data_perr = 0;
      check_rd(AW'(1), 32'h8210_0043, "R6 data parity sets bit 15");
      wr(AW'(1), 4'h8, 32'h8000_0000);

      // R7 system error gating
      ev_serr_sig = 1; cycle(); ev_serr_sig = 0;
      check_rd(AW'(1), 32'h0210_0043, "R7 serr ignored while disabled");
      wr(AW'(1), 4'h2, 32'h0000_0100);
      check_out(4'b1111, "R2 serr_en output");
      ev_serr_sig = 1; cycle(); ev_serr_sig = 0;
      check_rd(AW'(1), 32'h4210_0143, "R7 serr sets bit 14");

      // R9 data parity three conditions
      ev_perr_seen = 1; cycle(); ev_perr_seen = 0;
      check_rd(AW'(1), 32'h4210_0143, "R9 perr without master");
      ev_is_master = 1; cycle(); ev_is_master = 0;
      check_rd(AW'(1), 32'h4210_0143, "R9 master without perr");
      ev_perr_seen = 1; ev_is_master = 1; cycle(); ev_perr_seen = 0; ev_is_master = 0;
      check_rd(AW'(1), 32'h4310_0143, "R9 all conditions set bit 8");
      wr(AW'(1), 4'h1, 32'h0000_0003);
      wr(AW'(1), 4'h8, 32'h0100_0000);
      check_rd(AW'(1), 32'h4210_0103, "R4 bit 8 cleared");
      ev_perr_seen = 1; ev_is_master = 1; cycle(); ev_perr_seen = 0; ev_is_master = 0;
      check_rd(AW'(1), 32'h4210_0103, "R9 response disabled");

      // R8 abort flags
      ev_mabort = 1; cycle(); ev_mabort = 0;
      check_rd(AW'(1), 32'h6210_0103, "R8 master abort bit 13");
      ev_tabort_rcv = 1; cycle(); ev_tabort_rcv = 0;
      check_rd(AW'(1), 32'h7210_0103, "R8 target abort received bit 12");
      ev_tabort_sig = 1; cycle(); ev_tabort_sig = 0;
      check_rd(AW'(1), 32'h7A10_0103, "R8 target abort issued bit 11");

      // R10 set wins over clear
      ev_mabort = 1;
      wr(AW'(1), 4'h8, 32'hFF00_0000);
      ev_mabort = 0;
      check_rd(AW'(1), 32'h2210_0103, "R10 set beats clear");

      // R11 function reset
      frst_n = 1'b0; cycle(); frst_n = 1'b1;
      check_rd(AW'(1), 32'h2210_0000, "R11 function reset keeps flags");
      check_out(4'b0000, "R11 enables cleared");
      grst_n = 1'b0; cycle(); grst_n = 1'b1;
      check_rd(AW'(1), 32'h0210_0000, "R11 R1 global reset clears flags");

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule